// File: doc/BRIEF.md
# Mailbox Command Dispatcher

This block is the device-side sequencer of a host-driven command mailbox. The host loads a 64-bit command word that names a command group, a command code and an input payload length, then raises a doorbell. The block joins group and code into a 16-bit opcode and looks it up in a fixed table of supported commands. Each table entry carries the input length that command needs, or a wildcard for commands whose length varies.

A known opcode with an acceptable length is passed to an external handler through a one-cycle start pulse. The handler answers with a done pulse that carries a return code and an output length. Unknown opcodes and length mismatches are answered by the block itself, and the handler is never started for them. In every case the block writes the return code into the status word and rewrites the command word with the output length. Only in the following cycle does it drop the doorbell, which tells the host that the results can be read.

Top module: `mbx_dispatch`

## Requirements
- R1: The command word holds the command code in bits [7:0], the command group in bits [15:8] and the input length in bits [LEN_W+15:16]. The opcode is the group in the upper byte and the code in the lower byte. The handler start presents this opcode and the input length.
- R2: An opcode not in the table completes with return code 0x3. No handler start is issued, and the length field is loaded with 0.
- R3: The supported opcodes and their input lengths are: 0x0100 needs 1; 0x0102, 0x0200, 0x0300, 0x0400, 0x4000 and 0x4100 need 0; 0x0103 needs 4; 0x0301 and 0x4102 need 8; 0x0401 needs 0x18; 0x0101 and 0x4103 accept any length. A supported opcode with any other length completes with return code 0x16, issues no start, and loads the length field with 0.
- R4: On completion the status word holds the return code in bits [47:32], and all of its other bits are zero.
- R5: On completion, command word bits [15:0] are cleared, the length field takes the output length, and bits above the length field keep their value.
- R6: A host doorbell request while the doorbell is low sets it. The doorbell returns to 0 exactly one cycle after the status and command words are updated.
- R7: While the doorbell is high, host writes to the command word and further doorbell requests have no effect.
- R8: If the handler's output length exceeds PAYLOAD_BYTES, the command completes with return code 0x4 and the length field is loaded with 0.
- R9: The handler start lasts one cycle. The handler's return code and in-range output length are reported unchanged.
- R10: After reset the command word, status word, doorbell and handler start are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd_we | input | 1 | Host write strobe for the command word |
| host_cmd_wdata | input | 64 | Host data for the command word |
| host_db_set | input | 1 | Host request to raise the doorbell |
| cmd_reg | output | 64 | Command word |
| sts_reg | output | 64 | Status word |
| doorbell | output | 1 | Doorbell; high while a command is in flight |
| hnd_start | output | 1 | One-cycle handler start |
| hnd_opcode | output | 16 | Opcode presented to the handler |
| hnd_len | output | LEN_W | Input length presented to the handler |
| hnd_done | input | 1 | Handler completion pulse |
| hnd_rc | input | 16 | Handler return code |
| hnd_olen | input | LEN_W | Handler output length |

## Verification
Directed commands cover each table entry at its exact length, the two wildcard entries with random lengths, and each fixed-length entry one byte off, which separates the length check from the opcode lookup. Random opcodes from the whole 16-bit space, mixed with table hits, tell the unsupported path apart from the handler path. Handler output lengths straddling the payload limit separate pass-through from the internal-error override. Host writes and doorbell requests issued in the middle of a slow handler reply show whether the command word is protected while a command is in flight.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int CMD_W    = 64;
   localparam int CODE_LSB = 0;
   localparam int GRP_LSB  = 8;
   localparam int LEN_LSB  = 16;
   localparam int LEN_MAX  = 21;
   localparam int ERR_LSB  = 32;
   localparam int RC_W     = 16;

   localparam logic [RC_W-1:0] RC_OK       = 16'h0000;
   localparam logic [RC_W-1:0] RC_UNSUP    = 16'h0003;
   localparam logic [RC_W-1:0] RC_INTERNAL = 16'h0004;
   localparam logic [RC_W-1:0] RC_BAD_LEN  = 16'h0016;

   localparam int N_OPS   = 13;
   localparam int ANY_LEN = -1;

   localparam logic [15:0] OP_LIST [0:N_OPS-1] = '{
      16'h0100, 16'h0101, 16'h0102, 16'h0103, 16'h0200, 16'h0300, 16'h0301,
      16'h0400, 16'h0401, 16'h4000, 16'h4100, 16'h4102, 16'h4103 };
   localparam int OP_LEN [0:N_OPS-1] = '{
      1, ANY_LEN, 0, 4, 0, 0, 8, 0, 24, 0, 0, 8, ANY_LEN };

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WAIT    = 3'd1,
      ST_WRITE   = 3'd2,
      ST_RELEASE = 3'd3
   } mbx_state_e;
endpackage

// File: rtl/mbx_cmd_table.sv
module mbx_cmd_table
   import mbx_pkg::*;
#(
   parameter int LEN_W = 21
) (
   input  logic [15:0]      opcode,
   input  logic [LEN_W-1:0] in_len,
   output logic             hit,
   output logic             len_ok
);
   logic [N_OPS-1:0] match;
   logic [N_OPS-1:0] size_ok;

   for (genvar i = 0; i < N_OPS; i++) begin : g_entry
      assign match[i] = (opcode == OP_LIST[i]);
      if (OP_LEN[i] == ANY_LEN) begin : g_wild
         assign size_ok[i] = 1'b1;
      end else begin : g_fixed
         localparam logic [LEN_W-1:0] NEED = LEN_W'(OP_LEN[i]);
         assign size_ok[i] = (in_len == NEED);
      end
   end

   assign hit    = |match;
   assign len_ok = |(match & size_ok);
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
   import mbx_pkg::*;
#(
   parameter int LEN_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cmd_we,
   input  logic [CMD_W-1:0]  host_cmd_wdata,
   input  logic              host_db_set,
   input  logic              done_we,
   input  logic [LEN_W-1:0]  done_len,
   input  logic [RC_W-1:0]   done_rc,
   input  logic              db_clear,
   output logic [CMD_W-1:0]  cmd_reg,
   output logic [CMD_W-1:0]  sts_reg,
   output logic              doorbell
);
   logic [CMD_W-1:0] cmd_done;
   logic [CMD_W-1:0] sts_done;

   always_comb begin
      cmd_done                      = cmd_reg;
      cmd_done[GRP_LSB+7:CODE_LSB]  = '0;
      cmd_done[LEN_LSB +: LEN_W]    = done_len;
      sts_done                      = '0;
      sts_done[ERR_LSB +: RC_W]     = done_rc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_reg <= '0;
         sts_reg <= '0;
      end else if (done_we) begin
         cmd_reg <= cmd_done;
         sts_reg <= sts_done;
      end else if (host_cmd_we && !doorbell) begin
         cmd_reg <= host_cmd_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         doorbell <= 1'b0;
      end else if (db_clear) begin
         doorbell <= 1'b0;
      end else if (host_db_set && !doorbell) begin
         doorbell <= 1'b1;
      end
   end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
   import mbx_pkg::*;
#(
   parameter int LEN_W         = 21,
   parameter int PAYLOAD_BYTES = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              doorbell,
   input  logic [15:0]       opcode,
   input  logic [LEN_W-1:0]  in_len,
   input  logic              tbl_hit,
   input  logic              tbl_len_ok,
   input  logic              hnd_done,
   input  logic [RC_W-1:0]   hnd_rc,
   input  logic [LEN_W-1:0]  hnd_olen,
   output logic              hnd_start,
   output logic [15:0]       hnd_opcode,
   output logic [LEN_W-1:0]  hnd_len,
   output logic              done_we,
   output logic [LEN_W-1:0]  done_len,
   output logic [RC_W-1:0]   done_rc,
   output logic              db_clear
);
   localparam logic [LEN_W-1:0] LIMIT = LEN_W'(PAYLOAD_BYTES);

   mbx_state_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         hnd_start  <= 1'b0;
         hnd_opcode <= '0;
         hnd_len    <= '0;
         done_len   <= '0;
         done_rc    <= RC_OK;
      end else begin
         hnd_start <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (doorbell) begin
                  if (!tbl_hit) begin
                     done_rc  <= RC_UNSUP;
                     done_len <= '0;
                     state    <= ST_WRITE;
                  end else if (!tbl_len_ok) begin
                     done_rc  <= RC_BAD_LEN;
                     done_len <= '0;
                     state    <= ST_WRITE;
                  end else begin
                     hnd_start  <= 1'b1;
                     hnd_opcode <= opcode;
                     hnd_len    <= in_len;
                     state      <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (hnd_done) begin
                  if (hnd_olen > LIMIT) begin
                     done_rc  <= RC_INTERNAL;
                     done_len <= '0;
                  end else begin
                     done_rc  <= hnd_rc;
                     done_len <= hnd_olen;
                  end
                  state <= ST_WRITE;
               end
            end
            ST_WRITE:   state <= ST_RELEASE;
            ST_RELEASE: state <= ST_IDLE;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   assign done_we  = (state == ST_WRITE);
   assign db_clear = (state == ST_RELEASE);
endmodule

// File: rtl/mbx_dispatch.sv
module mbx_dispatch
   import mbx_pkg::*;
#(
   parameter int LEN_W         = 21,
   parameter int PAYLOAD_BYTES = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cmd_we,
   input  logic [63:0]       host_cmd_wdata,
   input  logic              host_db_set,
   output logic [63:0]       cmd_reg,
   output logic [63:0]       sts_reg,
   output logic              doorbell,
   output logic              hnd_start,
   output logic [15:0]       hnd_opcode,
   output logic [LEN_W-1:0]  hnd_len,
   input  logic              hnd_done,
   input  logic [15:0]       hnd_rc,
   input  logic [LEN_W-1:0]  hnd_olen
);
   if (LEN_W < 8 || LEN_W > LEN_MAX) begin : g_bad_len_w
      $error("mbx_dispatch: LEN_W must lie in 8..21");
   end
   if (PAYLOAD_BYTES < 1 || PAYLOAD_BYTES >= (1 << LEN_W)) begin : g_bad_payload
      $error("mbx_dispatch: PAYLOAD_BYTES must be below 2**LEN_W");
   end

   logic [15:0]      opcode;
   logic [LEN_W-1:0] in_len;
   logic             tbl_hit;
   logic             tbl_len_ok;
   logic             done_we;
   logic [LEN_W-1:0] done_len;
   logic [RC_W-1:0]  done_rc;
   logic             db_clear;

   assign opcode = {cmd_reg[GRP_LSB +: 8], cmd_reg[CODE_LSB +: 8]};
   assign in_len = cmd_reg[LEN_LSB +: LEN_W];

   mbx_cmd_table #(.LEN_W(LEN_W)) u_table (
      .opcode (opcode),
      .in_len (in_len),
      .hit    (tbl_hit),
      .len_ok (tbl_len_ok)
   );

   mbx_regs #(.LEN_W(LEN_W)) u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .host_cmd_we    (host_cmd_we),
      .host_cmd_wdata (host_cmd_wdata),
      .host_db_set    (host_db_set),
      .done_we        (done_we),
      .done_len       (done_len),
      .done_rc        (done_rc),
      .db_clear       (db_clear),
      .cmd_reg        (cmd_reg),
      .sts_reg        (sts_reg),
      .doorbell       (doorbell)
   );

   mbx_seq #(.LEN_W(LEN_W), .PAYLOAD_BYTES(PAYLOAD_BYTES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .doorbell   (doorbell),
      .opcode     (opcode),
      .in_len     (in_len),
      .tbl_hit    (tbl_hit),
      .tbl_len_ok (tbl_len_ok),
      .hnd_done   (hnd_done),
      .hnd_rc     (hnd_rc),
      .hnd_olen   (hnd_olen),
      .hnd_start  (hnd_start),
      .hnd_opcode (hnd_opcode),
      .hnd_len    (hnd_len),
      .done_we    (done_we),
      .done_len   (done_len),
      .done_rc    (done_rc),
      .db_clear   (db_clear)
   );
endmodule

// File: rtl/mbx_dispatch_chk.sv
module mbx_dispatch_chk #(
   parameter int LEN_W = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic [63:0]       cmd_reg,
   input logic [63:0]       sts_reg,
   input logic              doorbell,
   input logic              hnd_start,
   input logic [15:0]       hnd_opcode,
   input logic [LEN_W-1:0]  hnd_len
);
   AST_STS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_reg[63:48] == '0) && (sts_reg[31:0] == '0)); // R4

   AST_RELEASE_CLEARS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> (cmd_reg[15:0] == '0)); // R5

   AST_RELEASE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> ($stable(cmd_reg) && $stable(sts_reg))); // R6

   AST_CMD_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (doorbell && $past(doorbell) && ($past(cmd_reg[15:0]) != '0))
         |-> ($stable(cmd_reg) || (cmd_reg[15:0] == '0))); // R7

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_start |=> !hnd_start); // R9

   AST_START_MATCHES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_start |-> (doorbell && (hnd_opcode == cmd_reg[15:0])
                     && (hnd_len == cmd_reg[16 +: LEN_W]))); // R1
endmodule

bind mbx_dispatch mbx_dispatch_chk #(.LEN_W(LEN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_reg    (cmd_reg),
   .sts_reg    (sts_reg),
   .doorbell   (doorbell),
   .hnd_start  (hnd_start),
   .hnd_opcode (hnd_opcode),
   .hnd_len    (hnd_len)
);

// File: tb/mbx_dispatch_test.sv
module mbx_dispatch_test;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 21;
   localparam int PAYLOAD    = 2048;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_cmd_we = 1'b0;
   logic [63:0]       host_cmd_wdata = '0;
   logic              host_db_set = 1'b0;
   logic [63:0]       cmd_reg;
   logic [63:0]       sts_reg;
   logic              doorbell;
   logic              hnd_start;
   logic [15:0]       hnd_opcode;
   logic [LEN_W-1:0]  hnd_len;
   logic              hnd_done = 1'b0;
   logic [15:0]       hnd_rc = '0;
   logic [LEN_W-1:0]  hnd_olen = '0;

   int checks = 0;
   int fails  = 0;
   int starts = 0;
   logic [15:0]      seen_op;
   logic [LEN_W-1:0] seen_len;
   int               h_delay = 0;
   logic [15:0]      h_rc = '0;
   logic [LEN_W-1:0] h_olen = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_dispatch #(.LEN_W(LEN_W), .PAYLOAD_BYTES(PAYLOAD)) uut (
      .clk(clk), .rst_n(rst_n), .host_cmd_we(host_cmd_we),
      .host_cmd_wdata(host_cmd_wdata), .host_db_set(host_db_set),
      .cmd_reg(cmd_reg), .sts_reg(sts_reg), .doorbell(doorbell),
      .hnd_start(hnd_start), .hnd_opcode(hnd_opcode), .hnd_len(hnd_len),
      .hnd_done(hnd_done), .hnd_rc(hnd_rc), .hnd_olen(hnd_olen));

   // handler model
   initial begin
      forever begin
         @(negedge clk);
         if (hnd_start === 1'b1) begin
            starts++;
            seen_op  = hnd_opcode;
            seen_len = hnd_len;
            repeat (h_delay) @(negedge clk);
            @(negedge clk);
            hnd_done = 1'b1;
            hnd_rc   = h_rc;
            hnd_olen = h_olen;
            @(negedge clk);
            hnd_done = 1'b0;
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual run still going, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // required length: returns -1 for any length, -2 for unsupported
   function automatic int need_len(input logic [15:0] op);
      case (op)
         16'h0100: return 1;
         16'h0101, 16'h4103: return -1;
         16'h0102, 16'h0200, 16'h0300, 16'h0400, 16'h4000, 16'h4100: return 0;
         16'h0103: return 4;
         16'h0301, 16'h4102: return 8;
         16'h0401: return 24;
         default: return -2;
      endcase
   endfunction

   task automatic run_cmd(input logic [15:0] op, input logic [LEN_W-1:0] len,
                          input logic [15:0] rc, input logic [LEN_W-1:0] olen,
                          input int dly, input bit poke);
      logic [26:0] up;
      int need;
      bit  go;
      logic [15:0] exp_rc;
      logic [LEN_W-1:0] exp_len;
      int s0;
      int cnt;
      up = 27'($urandom);
      need = need_len(op);
      go = (need == -1) || (need >= 0 && int'(len) == need);
      if (need == -2) begin exp_rc = 16'h3; exp_len = '0; end
      else if (!go) begin exp_rc = 16'h16; exp_len = '0; end
      else if (int'(olen) > PAYLOAD) begin exp_rc = 16'h4; exp_len = '0; end
      else begin exp_rc = rc; exp_len = olen; end
      h_rc = rc; h_olen = olen; h_delay = dly;
      s0 = starts;
      @(negedge clk);
      host_cmd_we = 1'b1;
      host_cmd_wdata = {up, len, op};
      @(negedge clk);
      host_cmd_we = 1'b0;
      host_db_set = 1'b1;
      @(negedge clk);
      host_db_set = 1'b0;
      chk(doorbell === 1'b1, "R6 doorbell set", 64'(doorbell), 64'h1);
      if (poke) begin
         host_cmd_we = 1'b1;
         host_cmd_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
         host_db_set = 1'b1;
         @(negedge clk);
         host_cmd_we = 1'b0;
         host_db_set = 1'b0;
      end
      cnt = 0;
      while (doorbell === 1'b1 && cnt < 200) begin
         @(negedge clk);
         cnt++;
      end
      chk(cnt < 200, "R6 completion", 64'(cnt), 64'd0);
      chk(sts_reg === {16'h0, exp_rc, 32'h0}, "R4 status word", sts_reg,
          {16'h0, exp_rc, 32'h0});
      chk(cmd_reg === {up, exp_len, 16'h0}, "R5 command word", cmd_reg,
          {up, exp_len, 16'h0});
      chk((starts - s0) == (go ? 1 : 0), need == -2 ? "R2 no start" : "R3 start count",
          64'(starts - s0), go ? 64'd1 : 64'd0);
      if (go && starts != s0)
         chk(seen_op === op && seen_len === len, "R1 handler opcode/len",
             {seen_len, seen_op}, {len, op});
      if (poke) begin
         repeat (3) @(negedge clk);
         chk(doorbell === 1'b0 && starts == s0 + (go ? 1 : 0),
             "R7 busy writes ignored", 64'(doorbell), 64'd0);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk(cmd_reg === '0 && sts_reg === '0 && doorbell === 1'b0 && hnd_start === 1'b0,
          "R10 reset state", cmd_reg, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: every table entry at its length
      run_cmd(16'h0100, 1, 16'h0, 32, 0, 0);                  // R9
      run_cmd(16'h0102, 0, 16'h0, 4, 1, 0);
      run_cmd(16'h0103, 4, 16'h0, 0, 0, 0);
      run_cmd(16'h0200, 0, 16'h0, 80, 2, 0);
      run_cmd(16'h0300, 0, 16'h0, 8, 0, 0);
      run_cmd(16'h0301, 8, 16'h0, 0, 0, 0);
      run_cmd(16'h0400, 0, 16'h0, 28, 0, 0);
      run_cmd(16'h0401, 24, 16'h2, 0, 0, 0);                  // R9 rc passthrough
      run_cmd(16'h4000, 0, 16'h0, 67, 0, 0);
      run_cmd(16'h4100, 0, 16'h0, 32, 0, 0);
      run_cmd(16'h4102, 8, 16'h0, 100, 0, 0);
      // wildcards R3
      run_cmd(16'h0101, 0, 16'h0, 0, 0, 0);
      run_cmd(16'h4103, 1500, 16'h0, 0, 0, 0);
      // length off by one R3
      run_cmd(16'h0100, 2, 16'h0, 5, 0, 0);
      run_cmd(16'h0401, 23, 16'h0, 5, 0, 0);
      run_cmd(16'h4102, 9, 16'h0, 5, 0, 0);
      // unsupported R2
      run_cmd(16'h0104, 0, 16'h0, 5, 0, 0);
      run_cmd(16'hFFFF, 0, 16'h0, 5, 0, 0);
      // output length limit R8
      run_cmd(16'h0300, 0, 16'h0, 2048, 0, 0);
      run_cmd(16'h0300, 0, 16'h0, 2049, 0, 0);
      run_cmd(16'h0101, 7, 16'h0, 21'h1FFFFF, 1, 0);
      // busy writes R7
      run_cmd(16'h0301, 8, 16'h0, 12, 6, 1);
      run_cmd(16'h9999, 3, 16'h0, 12, 0, 1);

      // constrained random
      for (int i = 0; i < 150; i++) begin
         logic [15:0] op;
         logic [LEN_W-1:0] len;
         logic [LEN_W-1:0] olen;
         int n;
         int pick;
         pick = int'($urandom_range(0, 3));
         case (pick)
            0: op = 16'($urandom);
            1: op = {8'($urandom_range(0, 5)), 8'($urandom_range(0, 4))};
            default: begin
               logic [15:0] lst [13];
               lst = '{16'h0100, 16'h0101, 16'h0102, 16'h0103, 16'h0200, 16'h0300,
                       16'h0301, 16'h0400, 16'h0401, 16'h4000, 16'h4100, 16'h4102,
                       16'h4103};
               op = lst[$urandom_range(0, 12)];
            end
         endcase
         n = need_len(op);
         if (n >= 0 && $urandom_range(0, 2) != 0) len = LEN_W'(n);
         else len = LEN_W'($urandom_range(0, 40));
         olen = ($urandom_range(0, 5) == 0) ? LEN_W'($urandom_range(2040, 4000))
                                            : LEN_W'($urandom_range(0, 2048));
         run_cmd(op, len, 16'($urandom_range(0, 22)), olen,
                 int'($urandom_range(0, 4)), ($urandom_range(0, 7) == 0));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule